// File: doc/BRIEF.md
# Fixed-Interval Periodic Pulse Generator

This block drives periodic output pulses, one pulse per second being the usual case, that stay in step with a nanosecond time counter. The time counter is not inside the block. Instead, a time-advance strobe says when that counter moves forward, and a period input says by how many nanoseconds it moves. The block has two or three independent generator channels. Each channel keeps its own count of elapsed nanoseconds and its own programmable interval.

The interval register is programmed with the desired pulse period minus one nominal period. A channel fires when its elapsed count, after the strobe's advance is added, reaches the interval plus one nominal period. The count then restarts from zero. For example, a 10 ns period with an interval of 999999990 gives exactly one pulse per second.

All channels share one prescaler. The prescaler sets the output clock and therefore the pulse width: a pulse lasts for as many time-advance strobes as the prescaler value. Each pulse also sets a sticky per-channel event flag, which software clears by writing a 1 to that flag's bit.

Top module: `fiper_gen`

## Requirements
- R1: After synchronous reset, every pulse output is low and every event flag is clear.
- R2: Counting from a restart, channel k fires on strobe number ceil(I/P)+1, where I is its interval and P is the period input. After a firing, the next firing comes ceil(I/P)+1 strobes later. Firing raises the pulse in the cycle after the firing strobe.
- R3: A pulse stays high for W strobes, where W is the prescaler value written at address 0. A prescaler value of 0 acts as 1.
- R4: Pulse outputs change only in the cycle after a clock edge at which the strobe was high. While the strobe is low, pulses hold their level.
- R5: Writing channel k's interval (address 2+k, 32-bit data) restarts that channel's count from zero. Strobes seen before the write are forgotten.
- R6: Each firing sets that channel's event flag, which stays set.
- R7: A write to address 1 clears every event flag whose bit in the data is 1. When a firing and a clear hit the same flag in the same cycle, the flag stays set.
- R8: Channels run independently. Each one fires on its own interval from its own restart, and the channel count is a parameter (2 or 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Time-advance strobe |
| period_i | input | PER_W | Nanoseconds added per strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | ADDR_W | Register address: 0 prescaler, 1 event clear, 2+k interval of channel k |
| wr_data_i | input | CNT_W | Register write data |
| pulse_o | output | NCH | Pulse line per channel |
| evt_o | output | NCH | Sticky event flag per channel |

## Verification
The assertions assume that the strobe is the only time base. They also assume that event flags fall only in response to the clear write. For counting, the measurements assume that the period input stays constant and is nonzero, and that the interval leaves headroom below the counter's wrap point. The stimulus keeps within these limits: it changes the period and the intervals only while the strobe is low, and it drains any pulse that is still active before it restarts a channel. It also picks prescaler values shorter than the firing gap, so that each pulse has a measurable falling edge.

// File: rtl/fiper_pkg.sv
package fiper_pkg;

    localparam int unsigned ADDR_PRSC = 0;
    localparam int unsigned ADDR_CLR  = 1;
    localparam int unsigned ADDR_IVL0 = 2;

    typedef enum logic [1:0] {
        REG_PRSC = 2'd0,
        REG_CLR  = 2'd1,
        REG_IVL  = 2'd2,
        REG_NONE = 2'd3
    } reg_kind_t;

    // Sort a write address into the register it targets.
    function automatic reg_kind_t classify(input int unsigned addr, input int unsigned nch);
        if (addr == ADDR_PRSC)                              return REG_PRSC;
        else if (addr == ADDR_CLR)                          return REG_CLR;
        else if (addr >= ADDR_IVL0 && addr < ADDR_IVL0 + nch) return REG_IVL;
        else                                                return REG_NONE;
    endfunction

endpackage

// File: rtl/fiper_regs.sv
module fiper_regs
    import fiper_pkg::*;
#(
    parameter int unsigned NCH      = 3,
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned PSC_W    = 16,
    parameter int unsigned ADDR_W   = 4,
    parameter logic [31:0] RST_IVL  = 32'h3B9AC9F6,
    parameter logic [15:0] RST_PRSC = 16'd100
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en_i,
    input  logic [ADDR_W-1:0]           wr_addr_i,
    input  logic [CNT_W-1:0]            wr_data_i,
    output logic [PSC_W-1:0]            prsc_o,
    output logic [NCH-1:0][CNT_W-1:0]   ivl_o,
    output logic [NCH-1:0]              ivl_we_o,
    output logic [NCH-1:0]              clr_o
);

    reg_kind_t kind;

    always_comb begin
        kind = classify(int'(unsigned'(wr_addr_i)), NCH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prsc_o <= PSC_W'(RST_PRSC);
        end else if (wr_en_i && kind == REG_PRSC) begin
            prsc_o <= wr_data_i[PSC_W-1:0];
        end
    end

    always_comb begin
        clr_o = '0;
        if (wr_en_i && kind == REG_CLR) begin
            clr_o = wr_data_i[NCH-1:0];
        end
    end

    for (genvar k = 0; k < NCH; k++) begin : g_ivl
        assign ivl_we_o[k] = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_IVL0 + k));

        always_ff @(posedge clk) begin
            if (rst) begin
                ivl_o[k] <= CNT_W'(RST_IVL);
            end else if (ivl_we_o[k]) begin
                ivl_o[k] <= wr_data_i;
            end
        end
    end

endmodule

// File: rtl/fiper_chan.sv
module fiper_chan #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned PER_W = 8,
    parameter int unsigned PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [PER_W-1:0] period_i,
    input  logic [CNT_W-1:0] ivl_i,
    input  logic             restart_i,
    input  logic [PSC_W-1:0] width_i,
    output logic             fire_o,
    output logic             pulse_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [PSC_W-1:0] wid_q;
    logic             due;

    // Elapsed count plus this advance reaches interval plus one period.
    assign due    = (cnt_q >= ivl_i);
    assign fire_o = tick_i && !restart_i && due;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (due) cnt_q <= '0;
            else     cnt_q <= cnt_q + CNT_W'(period_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wid_q <= '0;
        end else if (fire_o) begin
            wid_q <= width_i;
        end else if (tick_i && wid_q != '0) begin
            wid_q <= wid_q - PSC_W'(1);
        end
    end

    assign pulse_o = (wid_q != '0);

endmodule

// File: rtl/fiper_events.sv
module fiper_events #(
    parameter int unsigned NCH = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] set_i,
    input  logic [NCH-1:0] clr_i,
    output logic [NCH-1:0] evt_o
);

    always_ff @(posedge clk) begin
        if (rst) evt_o <= '0;
        else     evt_o <= (evt_o & ~clr_i) | set_i;
    end

endmodule

// File: rtl/fiper_gen.sv
module fiper_gen
    import fiper_pkg::*;
#(
    parameter int unsigned NCH      = 3,
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned PER_W    = 8,
    parameter int unsigned PSC_W    = 16,
    parameter int unsigned ADDR_W   = 4,
    parameter logic [31:0] RST_IVL  = 32'h3B9AC9F6,
    parameter logic [15:0] RST_PRSC = 16'd100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [PER_W-1:0]  period_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic [NCH-1:0]    pulse_o,
    output logic [NCH-1:0]    evt_o
);

    logic [PSC_W-1:0]          prsc;
    logic [PSC_W-1:0]          width;
    logic [NCH-1:0][CNT_W-1:0] ivl;
    logic [NCH-1:0]            ivl_we;
    logic [NCH-1:0]            clr;
    logic [NCH-1:0]            fire;

    fiper_regs #(
        .NCH(NCH), .CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W),
        .RST_IVL(RST_IVL), .RST_PRSC(RST_PRSC)
    ) u_regs (
        .clk(clk), .rst(rst),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .prsc_o(prsc), .ivl_o(ivl), .ivl_we_o(ivl_we), .clr_o(clr)
    );

    // Prescaler of zero behaves as one output clock of one strobe.
    assign width = (prsc == '0) ? PSC_W'(1) : prsc;

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        fiper_chan #(.CNT_W(CNT_W), .PER_W(PER_W), .PSC_W(PSC_W)) u_chan (
            .clk(clk), .rst(rst),
            .tick_i(tick_i), .period_i(period_i),
            .ivl_i(ivl[k]), .restart_i(ivl_we[k]), .width_i(width),
            .fire_o(fire[k]), .pulse_o(pulse_o[k])
        );
    end

    fiper_events #(.NCH(NCH)) u_evt (
        .clk(clk), .rst(rst), .set_i(fire), .clr_i(clr), .evt_o(evt_o)
    );

endmodule

// File: rtl/fiper_chk.sv
module fiper_chk
    import fiper_pkg::*;
#(
    parameter int unsigned NCH    = 3,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [CNT_W-1:0]  wr_data_i,
    input logic [NCH-1:0]    pulse_o,
    input logic [NCH-1:0]    evt_o
);

    for (genvar k = 0; k < NCH; k++) begin : g_chk
        // R4
        pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !tick_i |=> $stable(pulse_o[k]));

        // R2
        pulse_rise_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(pulse_o[k]) |-> $past(tick_i));

        // R6
        pulse_sets_event_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(pulse_o[k]) |-> evt_o[k]);

        // R7
        event_clear_only_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(evt_o[k]) |->
                $past(wr_en_i && wr_addr_i == ADDR_W'(ADDR_CLR) && wr_data_i[k]));
    end

endmodule

bind fiper_gen fiper_chk #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .pulse_o(pulse_o), .evt_o(evt_o)
);

// File: tb/fiper_gen_tb.sv
module fiper_gen_tb;

    localparam int NCH = 3;

    logic             clk = 0;
    logic             rst = 1;
    logic             tick = 0;
    logic [7:0]       period = 8'd10;
    logic             wr_en = 0;
    logic [3:0]       wr_addr = '0;
    logic [31:0]      wr_data = '0;
    logic [NCH-1:0]   pulse;
    logic [NCH-1:0]   evt;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fiper_gen #(.NCH(NCH)) u_dut (
        .clk(clk), .rst(rst), .tick_i(tick), .period_i(period),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .pulse_o(pulse), .evt_o(evt)
    );

    // interval, period, prescaler, strobes to first rise (= gap), width
    localparam int VEC [0:5][0:4] = '{
        '{90, 10, 3, 10, 3},
        '{40,  8, 0,  6, 1},
        '{14,  7, 2,  3, 2},
        '{35,  5, 4,  8, 4},
        '{99, 10, 2, 11, 2},
        '{60, 20, 1,  4, 1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        wr_en = 1; wr_addr = 4'(addr); wr_data = 32'(data);
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic drain(input int ch);
        tick = 1;
        while (pulse[ch]) begin
            @(posedge clk); #1;
        end
        tick = 0;
    endtask

    task automatic count_to_rise(input int ch, output int n);
        n = 0;
        tick = 1;
        do begin
            @(posedge clk); #1;
            n++;
        end while (!pulse[ch] && n < 1000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, w, g, n1, n2;
        bit low_seen;

        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1
        chk("R1 pulses after reset", int'(pulse), 0);
        chk("R1 events after reset", int'(evt), 0);

        // R2 R3 vector table on channel 0
        for (int v = 0; v < 6; v++) begin
            drain(0);
            wr(0, VEC[v][2]);
            period = 8'(VEC[v][1]);
            wr(2, VEC[v][0]);
            count_to_rise(0, n);
            chk($sformatf("R2 first rise vec%0d", v), n, VEC[v][3]);
            w = 1; g = 0; low_seen = 0;
            while (g < 1000) begin
                @(posedge clk); #1;
                g++;
                if (pulse[0]) begin
                    if (low_seen) break;
                    w++;
                end else low_seen = 1;
            end
            chk($sformatf("R3 width vec%0d", v), w, VEC[v][4]);
            chk($sformatf("R2 gap vec%0d", v), g, VEC[v][3]);
            tick = 0;
        end

        // R6 sticky flag on channel 0 only; R8 others untouched
        repeat (3) @(posedge clk); #1;
        chk("R6 event ch0 sticky", int'(evt[0]), 1);
        chk("R8 event ch1 untouched", int'(evt[1]), 0);

        // R7 clear by write-one
        wr(1, 32'h2);
        chk("R7 clear of zero-bit keeps ch0", int'(evt[0]), 1);
        wr(1, 32'h1);
        chk("R7 clear ch0", int'(evt[0]), 0);

        // R4 strobe stall keeps pulse level
        drain(0);
        wr(0, 5);
        period = 8'd10;
        wr(2, 90);
        count_to_rise(0, n);
        tick = 0;
        n = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1;
            if (pulse[0]) n++;
        end
        chk("R4 pulse held while strobe low", n, 8);
        tick = 1; w = 0;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1;
            if (pulse[0]) w++;
            else break;
        end
        chk("R4 remaining width after stall", w, 4);
        tick = 0;

        // R5 rewrite restarts count
        wr(0, 1);
        drain(1);
        wr(3, 50);
        tick = 1;
        repeat (3) @(posedge clk); #1;
        tick = 0;
        wr(3, 50);
        count_to_rise(1, n);
        chk("R5 rise counted from rewrite", n, 6);
        tick = 0;

        // R8 two channels from a common restart
        drain(1);
        drain(2);
        wr(3, 20);
        wr(4, 30);
        tick = 1; n1 = 0; n2 = 0;
        for (int i = 1; i <= 10; i++) begin
            @(posedge clk); #1;
            if (pulse[1] && n1 == 0) n1 = i;
            if (pulse[2] && n2 == 0) n2 = i;
        end
        tick = 0;
        chk("R8 ch1 first rise", n1, 3);
        chk("R8 ch2 first rise", n2, 4);

        // R7 set wins over same-cycle clear
        wr(2, 0);
        tick = 1;
        repeat (2) @(posedge clk); #1;
        wr_en = 1; wr_addr = 4'd1; wr_data = 32'h1;
        @(posedge clk); #1;
        wr_en = 0;
        chk("R7 set wins over clear", int'(evt[0]), 1);
        tick = 0;
        @(posedge clk); #1;
        wr(1, 32'h1);
        chk("R7 clear without firing", int'(evt[0]), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule